// File: doc/BRIEF.md
# Repacking Transmit/Receive FIFO Port

This block sits between a 32-bit register bus and a byte-oriented serial bus engine. Software writes 32-bit words to a transmit port and the block splits each word into two 16-bit entries. The engine takes these entries one at a time through a valid/ready handshake. In the other direction the engine delivers received bytes one at a time. The block packs them in pairs so that one 32-bit read from the receive port returns two bytes. Both stores are sized at elaboration from a 2-bit block-size code and a 3-bit depth code.

Each direction counts its traffic against a programmed target. In FIFO mode one shared count register serves both directions, and a done flag is raised when the target is reached. In block mode each direction has its own count register. A service flag is then raised on every block boundary, so software can refill or drain one block at a time. Occupancy, service and done flags sit in one status register. Two error flags record a write to a full transmit store and a read from an empty receive store. An interrupt output combines the flags.

Top module: `repack_fifo_port`

## Requirements
- R1: After reset the following values hold. Status (0x04), error (0x08) and error-enable (0x0C) read 0. Mode (0x00) reads 0x0000C000. `irq` and `tx_valid` are 0 and `rx_ready` is 1. The size register (0x1C) reports the block-size codes at bits 1:0 (transmit) and 6:5 (receive), and the depth codes at bits 4:2 (transmit) and 9:7 (receive).
- R2: With mode bit 14 (unpack) set, a write to the transmit port (0x20) yields two entries: bits 15:0 first, then bits 31:16. With bit 14 clear, the write yields only the bits 15:0 entry.
- R3: The transmit store holds depth/2 words, where depth = block words × (2 << depth code) and block words are 4, 16 or 32 for codes 0, 1, 2. A write to 0x20 while status bit 6 (transmit full) is set is discarded and sets error bit 0.
- R4: With mode bit 15 (pack) set, a read of the receive port (0x24) returns the first byte in bits 7:0 and the second in bits 23:16, with all other bits 0. When the count target ends on an odd byte, that byte is returned alone. With bit 15 clear, each read returns one byte in bits 7:0.
- R5: A read of 0x24 while the receive store is empty returns 0 and sets error bit 1.
- R6: Status bit 4 shows that transmit data is still held. Bit 5 shows that the receive store is not empty. Bit 6 shows that the transmit store is full. `rx_ready` is low while the receive store is full.
- R7: With mode bit 10 clear, the transmit target is the shared count (0x10) and no service flag is raised. With bit 10 set, the target is register 0x14 and status bit 8 is set after every block of entries taken. In both modes, status bit 10 is set when the entries taken reach a nonzero target.
- R8: With mode bit 12 clear, the receive target is the shared count (0x10). With bit 12 set, the target is register 0x18 and status bit 9 is set after every block of received bytes. In both modes, status bit 11 is set when the received bytes reach a nonzero target.
- R9: Writing 1 to status bits 8–11 or error bits 1:0 clears them. If a flag is set by hardware in the same cycle as its clear, the set wins.
- R10: `irq` is high one cycle after any of status bits 8–11 is set, or after any error bit is set whose enable bit in 0x0C is set. An error bit whose enable is clear does not raise `irq`.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_entry` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit entry available |
| tx_entry | output | 16 | Transmit entry |
| tx_ready | input | 1 | Engine takes the entry |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Block can accept a byte |

## Verification
The transmit handshake can cross a block boundary in the same cycle in which software writes 1 to clear the transmit service flag. The bench takes three entries of a block one by one and waits until the fourth is presented. On a single falling edge it then raises `tx_ready` and issues the clearing write to the status register. A later status read must still show bit 8 set. A second clearing write, with no boundary in its cycle, must then leave the flag clear.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
  // Register byte addresses
  localparam logic [5:0] A_MODE  = 6'h00;
  localparam logic [5:0] A_FLAGS = 6'h04;
  localparam logic [5:0] A_ERR   = 6'h08;
  localparam logic [5:0] A_ERREN = 6'h0C;
  localparam logic [5:0] A_FCNT  = 6'h10;
  localparam logic [5:0] A_OCNT  = 6'h14;
  localparam logic [5:0] A_ICNT  = 6'h18;
  localparam logic [5:0] A_SIZE  = 6'h1C;
  localparam logic [5:0] A_TXP   = 6'h20;
  localparam logic [5:0] A_RXP   = 6'h24;

  // Status bit positions
  localparam int F_ONE   = 4;
  localparam int F_INE   = 5;
  localparam int F_OFULL = 6;
  localparam int F_OSVC  = 8;
  localparam int F_ISVC  = 9;
  localparam int F_ODONE = 10;
  localparam int F_IDONE = 11;

  // Mode bit positions
  localparam int M_OBLK = 10;
  localparam int M_IBLK = 12;
  localparam int M_UNPK = 14;
  localparam int M_PACK = 15;

  // Block size in words from its 2-bit code (codes above 2 are unsupported)
  function automatic int blk_words(input int code);
    case (code)
      0:       return 4;
      1:       return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int depth_entries(input int blk_code, input int depth_code);
    return blk_words(blk_code) * (2 << depth_code);
  endfunction
endpackage

// File: rtl/rfp_store.sv
module rfp_store #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [0:DEPTH-1];
  logic [AW:0]  wptr_q, rptr_q;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);

  // Memory without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wptr_q[AW-1:0]] <= wr_data;
    if (rd_en && !empty) rd_data <= mem[rptr_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_en && !full)  wptr_q <= wptr_q + (AW+1)'(1);
      if (rd_en && !empty) rptr_q <= rptr_q + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/rfp_tally.sv
module rfp_tally #(
  parameter int CNT_W = 16,
  parameter int BLK   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] target,
  output logic             last_hit,
  output logic             blk_hit
);
  localparam int BW = $clog2(BLK);

  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    bcnt_q;
  logic             active;

  // Counting runs only while a nonzero target is not yet reached
  assign active   = step && (target != '0) && (cnt_q != target);
  assign last_hit = active && ((cnt_q + CNT_W'(1)) == target);
  assign blk_hit  = active && (bcnt_q == BW'(BLK - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
    end else if (active) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      bcnt_q <= blk_hit ? '0 : bcnt_q + BW'(1);
    end
  end
endmodule

// File: rtl/repack_fifo_port.sv
module repack_fifo_port
  import fifo_port_pkg::*;
#(
  parameter int OUT_BLK_CODE  = 0,
  parameter int OUT_FIFO_CODE = 0,
  parameter int IN_BLK_CODE   = 0,
  parameter int IN_FIFO_CODE  = 0,
  parameter int CNT_W         = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [15:0] tx_entry,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        rx_ready
);
  localparam int OUT_BLK   = blk_words(OUT_BLK_CODE);
  localparam int IN_BLK    = blk_words(IN_BLK_CODE);
  localparam int OUT_DEPTH = depth_entries(OUT_BLK_CODE, OUT_FIFO_CODE);
  localparam int IN_DEPTH  = depth_entries(IN_BLK_CODE, IN_FIFO_CODE);
  localparam int OUT_AW    = $clog2(OUT_DEPTH / 2);
  localparam int IN_AW     = $clog2(IN_DEPTH / 2);
  localparam logic [31:0] SIZE_WORD = {22'd0, 3'(IN_FIFO_CODE), 2'(IN_BLK_CODE),
                                       3'(OUT_FIFO_CODE), 2'(OUT_BLK_CODE)};

  // Control registers
  logic             obl_q, ibl_q, unpk_q, pack_q;
  logic [1:0]       err_q, err_en_q;
  logic [CNT_W-1:0] fcnt_q, ocnt_q, icnt_q;
  logic             osvc_q, isvc_q, odone_q, idone_q;

  logic wr_mode, wr_flags, wr_err, wr_txp, rd_rxp, cnt_clr;
  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
  assign wr_err   = bus_wr && (bus_addr == A_ERR);
  assign wr_txp   = bus_wr && (bus_addr == A_TXP);
  assign rd_rxp   = bus_rd && (bus_addr == A_RXP);
  assign cnt_clr  = wr_mode || (bus_wr && (bus_addr == A_FCNT || bus_addr == A_OCNT
                                           || bus_addr == A_ICNT));

  // ---------------- transmit side ----------------
  logic [32:0] o_rd;
  logic        o_full, o_empty, o_fetch, fetch_q;
  logic        st_v_q, hi_pend_q;
  logic [15:0] cur_q, hi_keep_q;
  logic        tx_fire, o_last_hit, o_blk_hit;

  assign o_fetch = !st_v_q && !fetch_q && !o_empty;
  assign tx_fire = st_v_q && tx_ready;

  rfp_store #(.W(33), .AW(OUT_AW)) u_out_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_txp), .wr_data({unpk_q, bus_wdata}),
    .rd_en(o_fetch), .rd_data(o_rd),
    .full(o_full), .empty(o_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q   <= 1'b0;
      st_v_q    <= 1'b0;
      hi_pend_q <= 1'b0;
      cur_q     <= '0;
      hi_keep_q <= '0;
    end else begin
      fetch_q <= o_fetch;
      if (fetch_q) begin
        st_v_q    <= 1'b1;
        cur_q     <= o_rd[15:0];
        hi_keep_q <= o_rd[31:16];
        hi_pend_q <= o_rd[32];
      end else if (tx_fire) begin
        if (hi_pend_q) begin
          cur_q     <= hi_keep_q;
          hi_pend_q <= 1'b0;
        end else begin
          st_v_q <= 1'b0;
        end
      end
    end
  end

  assign tx_valid = st_v_q;
  assign tx_entry = cur_q;

  rfp_tally #(.CNT_W(CNT_W), .BLK(OUT_BLK)) u_out_tally (
    .clk(clk), .rst(rst), .clr(cnt_clr), .step(tx_fire),
    .target(obl_q ? ocnt_q : fcnt_q),
    .last_hit(o_last_hit), .blk_hit(o_blk_hit)
  );

  // ---------------- receive side ----------------
  logic [15:0] i_rd, i_wdata;
  logic        i_full, i_empty, i_push, rx_fire, i_last_hit, i_blk_hit;
  logic        stg_v_q, stg_load, stg_take;
  logic [7:0]  stg_b_q;

  assign rx_ready = !i_full;
  assign rx_fire  = rx_valid && !i_full;

  rfp_tally #(.CNT_W(CNT_W), .BLK(IN_BLK)) u_in_tally (
    .clk(clk), .rst(rst), .clr(cnt_clr), .step(rx_fire),
    .target(ibl_q ? icnt_q : fcnt_q),
    .last_hit(i_last_hit), .blk_hit(i_blk_hit)
  );

  always_comb begin
    i_push   = 1'b0;
    i_wdata  = '0;
    stg_load = 1'b0;
    stg_take = 1'b0;
    if (rx_fire) begin
      if (!pack_q) begin
        i_push  = 1'b1;
        i_wdata = {8'h00, rx_byte};
      end else if (stg_v_q) begin
        i_push   = 1'b1;
        i_wdata  = {rx_byte, stg_b_q};
        stg_take = 1'b1;
      end else if (i_last_hit) begin
        i_push  = 1'b1;
        i_wdata = {8'h00, rx_byte};
      end else begin
        stg_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      stg_v_q <= 1'b0;
      stg_b_q <= '0;
    end else if (stg_load) begin
      stg_v_q <= 1'b1;
      stg_b_q <= rx_byte;
    end else if (stg_take) begin
      stg_v_q <= 1'b0;
    end
  end

  rfp_store #(.W(16), .AW(IN_AW)) u_in_store (
    .clk(clk), .rst(rst),
    .wr_en(i_push), .wr_data(i_wdata),
    .rd_en(rd_rxp), .rd_data(i_rd),
    .full(i_full), .empty(i_empty)
  );

  // ---------------- registers and flags ----------------
  logic [31:0] w1c;
  logic [1:0]  err_set, err_clr;
  assign w1c     = wr_flags ? bus_wdata : 32'd0;
  assign err_clr = wr_err ? bus_wdata[1:0] : 2'b00;
  assign err_set = {rd_rxp && i_empty, wr_txp && o_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      obl_q    <= 1'b0;
      ibl_q    <= 1'b0;
      unpk_q   <= 1'b1;
      pack_q   <= 1'b1;
      err_en_q <= '0;
      fcnt_q   <= '0;
      ocnt_q   <= '0;
      icnt_q   <= '0;
      err_q    <= '0;
      osvc_q   <= 1'b0;
      isvc_q   <= 1'b0;
      odone_q  <= 1'b0;
      idone_q  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_mode) begin
        obl_q  <= bus_wdata[M_OBLK];
        ibl_q  <= bus_wdata[M_IBLK];
        unpk_q <= bus_wdata[M_UNPK];
        pack_q <= bus_wdata[M_PACK];
      end
      if (bus_wr && bus_addr == A_ERREN) err_en_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_FCNT)  fcnt_q   <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == A_OCNT)  ocnt_q   <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == A_ICNT)  icnt_q   <= bus_wdata[CNT_W-1:0];
      // hardware set takes priority over software clear
      err_q   <= err_set | (err_q & ~err_clr);
      osvc_q  <= (obl_q && o_blk_hit) | (osvc_q & ~w1c[F_OSVC]);
      isvc_q  <= (ibl_q && i_blk_hit) | (isvc_q & ~w1c[F_ISVC]);
      odone_q <= o_last_hit | (odone_q & ~w1c[F_ODONE]);
      idone_q <= i_last_hit | (idone_q & ~w1c[F_IDONE]);
      irq     <= osvc_q | isvc_q | odone_q | idone_q | (|(err_q & err_en_q));
    end
  end

  // ---------------- read path ----------------
  logic [31:0] flags_word, reg_mux, reg_q;
  logic        pop_sel_q;

  always_comb begin
    flags_word          = '0;
    flags_word[F_ONE]   = !o_empty || fetch_q || st_v_q;
    flags_word[F_INE]   = !i_empty;
    flags_word[F_OFULL] = o_full;
    flags_word[F_OSVC]  = osvc_q;
    flags_word[F_ISVC]  = isvc_q;
    flags_word[F_ODONE] = odone_q;
    flags_word[F_IDONE] = idone_q;
  end

  always_comb begin
    reg_mux = '0;
    case (bus_addr)
      A_MODE:  reg_mux = {16'd0, pack_q, unpk_q, 1'b0, ibl_q, 1'b0, obl_q, 10'd0};
      A_FLAGS: reg_mux = flags_word;
      A_ERR:   reg_mux = {30'd0, err_q};
      A_ERREN: reg_mux = {30'd0, err_en_q};
      A_FCNT:  reg_mux = 32'(fcnt_q);
      A_OCNT:  reg_mux = 32'(ocnt_q);
      A_ICNT:  reg_mux = 32'(icnt_q);
      A_SIZE:  reg_mux = SIZE_WORD;
      default: reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      pop_sel_q <= 1'b0;
    end else begin
      pop_sel_q <= rd_rxp && !i_empty;
      if (bus_rd) reg_q <= reg_mux;
    end
  end

  assign bus_rdata = pop_sel_q ? {8'h00, i_rd[15:8], 8'h00, i_rd[7:0]} : reg_q;
endmodule

// File: rtl/repack_fifo_port_chk.sv
module repack_fifo_port_chk
  import fifo_port_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [5:0]  bus_addr,
  input logic        clr_odone_bit,
  input logic [31:0] bus_rdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [15:0] tx_entry,
  input logic        irq,
  input logic        o_full,
  input logic        i_empty,
  input logic [1:0]  err_q,
  input logic        obl_q,
  input logic        o_blk_hit,
  input logic        osvc_q,
  input logic        isvc_q,
  input logic        odone_q,
  input logic        idone_q
);
  p_overflow_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TXP && o_full) |=> err_q[0]);

  p_underrun_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RXP && i_empty) |=> (bus_rdata == 32'd0 && err_q[1]));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_entry)));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (odone_q && !(bus_wr && bus_addr == A_FLAGS && clr_odone_bit)) |=> odone_q);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (obl_q && o_blk_hit) |=> osvc_q);

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (osvc_q || isvc_q || odone_q || idone_q) |=> irq);
endmodule

bind repack_fifo_port repack_fifo_port_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .clr_odone_bit(bus_wdata[10]), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_entry(tx_entry), .irq(irq), .o_full(o_full),
  .i_empty(i_empty), .err_q(err_q), .obl_q(obl_q), .o_blk_hit(o_blk_hit),
  .osvc_q(osvc_q), .isvc_q(isvc_q), .odone_q(odone_q), .idone_q(idone_q)
);

// File: tb/repack_fifo_port_bench.sv
`timescale 1ns/1ps
module repack_fifo_port_bench;
  import fifo_port_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [15:0] tx_entry;
  logic [7:0]  rx_byte = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  repack_fifo_port u_repack_fifo_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_entry(tx_entry), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready)
  );

  // unpack, data word, first entry, second entry
  localparam logic [64:0] TBL [0:4] = '{
    {1'b1, 32'hBEEF_CAFE, 16'hCAFE, 16'hBEEF},
    {1'b1, 32'h0001_FFFF, 16'hFFFF, 16'h0001},
    {1'b0, 32'h1234_5678, 16'h5678, 16'h0000},
    {1'b1, 32'h8000_0000, 16'h0000, 16'h8000},
    {1'b0, 32'hFFFF_00A5, 16'h00A5, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tx_take(output logic [15:0] e);
    bit got = 0;
    e = 16'hxxxx;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (tx_valid) begin
        e = tx_entry;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        got = 1;
      end
    end
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    for (int i = 0; i < 40 && !rx_ready; i++) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] e;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(A_MODE, v);  chk("R1 mode", v, 32'h0000_C000);
    bus_read(A_FLAGS, v); chk("R1 flags", v, 32'd0);
    bus_read(A_ERR, v);   chk("R1 err", v, 32'd0);
    bus_read(A_SIZE, v);  chk("R1 size", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);

    // R2 table of split patterns
    foreach (TBL[k]) begin
      bus_write(A_MODE, TBL[k][64] ? 32'h0000_C000 : 32'h0000_8000);
      bus_write(A_TXP, TBL[k][63:32]);
      tx_take(e); chk("R2 first entry", {16'd0, e}, {16'd0, TBL[k][31:16]});
      if (TBL[k][64]) begin
        tx_take(e); chk("R2 second entry", {16'd0, e}, {16'd0, TBL[k][15:0]});
      end
      idle(4);
      chk("R2 no extra entry", {31'd0, tx_valid}, 32'd0);
    end

    // R6 / R3 occupancy and overflow
    bus_write(A_MODE, 32'h0000_C000);
    bus_read(A_FLAGS, v); chk("R6 out empty", {31'd0, v[4]}, 32'd0);
    bus_write(A_TXP, {16'h0101, 16'h0100});
    bus_read(A_FLAGS, v); chk("R6 out not empty", {31'd0, v[4]}, 32'd1);
    for (int k = 1; k < 5; k++)
      bus_write(A_TXP, {16'h0101 + 16'(2*k), 16'h0100 + 16'(2*k)});
    bus_read(A_FLAGS, v); chk("R3 out full", {31'd0, v[6]}, 32'd1);
    bus_read(A_ERR, v);   chk("R3 no err yet", v, 32'd0);
    bus_write(A_TXP, 32'hDEAD_DEAD);
    bus_read(A_ERR, v);   chk("R3 overflow flag", v, 32'd1);
    idle(2);
    chk("R10 masked err no irq", {31'd0, irq}, 32'd0);
    bus_write(A_ERREN, 32'd1);
    idle(2);
    chk("R10 enabled err irq", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 10; k++) begin
      tx_take(e);
      chk("R3 drain order", {16'd0, e}, {16'd0, 16'h0100 + 16'(k)});
    end
    idle(4);
    chk("R3 discarded write absent", {31'd0, tx_valid}, 32'd0);
    bus_read(A_FLAGS, v); chk("R6 drained", v & 32'h70, 32'd0);
    bus_write(A_ERR, 32'd1);
    bus_read(A_ERR, v); chk("R9 err clear", v, 32'd0);
    idle(2);
    chk("R10 irq drops", {31'd0, irq}, 32'd0);

    // R5 underrun
    bus_read(A_RXP, v); chk("R5 empty read zero", v, 32'd0);
    bus_read(A_ERR, v); chk("R5 underrun flag", v, 32'd2);
    bus_write(A_ERR, 32'd3);

    // R4 packing with odd final byte
    bus_write(A_FCNT, 32'd3);
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
    idle(2);
    bus_read(A_FLAGS, v);
    chk("R6 in not empty", {31'd0, v[5]}, 32'd1);
    chk("R8 fifo-mode in done", {31'd0, v[11]}, 32'd1);
    bus_read(A_RXP, v); chk("R4 packed pair", v, 32'h0022_0011);
    bus_read(A_RXP, v); chk("R4 odd last byte", v, 32'h0000_0033);
    bus_write(A_FLAGS, 32'h800);
    bus_read(A_FLAGS, v); chk("R9 done clear", v, 32'd0);
    bus_write(A_MODE, 32'h0000_4000);
    bus_write(A_FCNT, 32'd0);
    rx_send(8'h5A); idle(2);
    bus_read(A_RXP, v); chk("R4 pack off", v, 32'h0000_005A);

    // R8 receive block mode
    bus_write(A_MODE, 32'h0000_D000);
    bus_write(A_ICNT, 32'd8);
    for (int k = 1; k <= 4; k++) rx_send(8'(k));
    idle(2);
    bus_read(A_FLAGS, v);
    chk("R8 in service", {31'd0, v[9]}, 32'd1);
    chk("R8 not yet done", {31'd0, v[11]}, 32'd0);
    bus_write(A_FLAGS, 32'h200);
    bus_read(A_FLAGS, v); chk("R9 svc clear", {31'd0, v[9]}, 32'd0);
    for (int k = 5; k <= 8; k++) rx_send(8'(k));
    idle(2);
    bus_read(A_FLAGS, v);
    chk("R8 second service", {31'd0, v[9]}, 32'd1);
    chk("R8 in done", {31'd0, v[11]}, 32'd1);
    chk("R6 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    bus_read(A_RXP, v); chk("R8 first word", v, 32'h0002_0001);
    bus_read(A_RXP, v); bus_read(A_RXP, v);
    bus_read(A_RXP, v); chk("R8 last word", v, 32'h0008_0007);
    bus_write(A_FLAGS, 32'hF00);

    // R7 / R9 transmit block mode with set and clear in one cycle
    bus_write(A_MODE, 32'h0000_C400);
    bus_write(A_OCNT, 32'd8);
    bus_write(A_TXP, 32'h0002_0001);
    bus_write(A_TXP, 32'h0004_0003);
    for (int k = 1; k <= 3; k++) begin
      tx_take(e); chk("R7 block entry", {16'd0, e}, 32'(k));
    end
    bus_read(A_FLAGS, v); chk("R7 no service mid block", {31'd0, v[8]}, 32'd0);
    for (int i = 0; i < 40 && !tx_valid; i++) @(negedge clk);
    @(negedge clk);
    tx_ready = 1'b1;
    bus_wr = 1'b1; bus_addr = A_FLAGS; bus_wdata = 32'h100;
    @(negedge clk);
    tx_ready = 1'b0; bus_wr = 1'b0;
    bus_read(A_FLAGS, v); chk("R9 set wins over clear", {31'd0, v[8]}, 32'd1);
    bus_write(A_FLAGS, 32'h100);
    bus_read(A_FLAGS, v); chk("R9 plain clear", {31'd0, v[8]}, 32'd0);
    bus_write(A_TXP, 32'h0006_0005);
    bus_write(A_TXP, 32'h0008_0007);
    for (int k = 5; k <= 8; k++) begin
      tx_take(e); chk("R7 block entry", {16'd0, e}, 32'(k));
    end
    idle(2);
    bus_read(A_FLAGS, v);
    chk("R7 out service", {31'd0, v[8]}, 32'd1);
    chk("R7 out done", {31'd0, v[10]}, 32'd1);
    chk("R10 flag irq", {31'd0, irq}, 32'd1);
    bus_write(A_FLAGS, 32'hF00);

    // R7 FIFO mode: done without service
    bus_write(A_MODE, 32'h0000_C000);
    bus_write(A_FCNT, 32'd2);
    bus_write(A_TXP, 32'h0000_0009);
    tx_take(e); tx_take(e);
    idle(2);
    bus_read(A_FLAGS, v);
    chk("R7 fifo-mode done", {31'd0, v[10]}, 32'd1);
    chk("R7 fifo-mode no service", {31'd0, v[8]}, 32'd0);

    // R11 entry holds while not ready
    bus_write(A_TXP, 32'h0000_7777);
    idle(6);
    chk("R11 valid held", {31'd0, tx_valid}, 32'd1);
    chk("R11 entry held", {16'd0, tx_entry}, 32'h7777);
    idle(4);
    chk("R11 entry still held", {16'd0, tx_entry}, 32'h7777);

    finish_run();
  end
endmodule